// File: doc/BRIEF.md
# Translation Context Qualifier and Fault Reporter

This block sits in front of a radix page-table walker. It looks at each access request and decides which translation context applies. The two top bits of the 64-bit effective address form a quadrant. The quadrant, together with the hypervisor mode bit, selects whether the partition identifier and the process identifier come from their registers or are forced to zero. In guest mode two of the four quadrants are not legal, and a request that lands in one of them produces a segment fault.

When the hypervisor bit is set and the relocation enable for the access kind is off, the access runs in real mode. The translated address is then the effective address with its top four bits cleared, and read, write and execute are all granted. The qualifier outputs are combinational.

The walker reports storage faults back through a separate fault input. The block turns either kind of fault into one registered record. The record holds the exception kind, the status value, the address to capture and the error code, and a one-cycle valid strobe marks it.

Top module: `xlat_ctx_qualifier`

## Requirements
- R1: The access code on `acc_type` is 0 for a read, 1 for a write and 2 for an instruction fetch. Code 3 is handled as a data read. The same encoding applies to `sf_acc`.
- R2: With `hv_mode`=1, the quadrant `ea[63:62]` maps as follows. Quadrant 0 gives partition 0 and the process register. Quadrant 1 gives both registers. Quadrant 2 gives the partition register and process 0. Quadrant 3 gives partition 0 and process 0. `qual_legal`=1 in all four quadrants.
- R3: With `hv_mode`=0, quadrant 0 gives both registers and quadrant 3 gives the partition register and process 0, with `qual_legal`=1. Quadrants 1 and 2 give `qual_legal`=0.
- R4: A request with `req_valid`=1 that is not real mode and has `qual_legal`=0 produces a fault record one clock later. For a fetch the kind is 1 (instruction segment), with `flt_addr_we`=0. For any other access the kind is 2 (data segment), `flt_addr` holds `ea` and `flt_addr_we`=1. In both cases `flt_errcode`=0 and `flt_status_we`=0.
- R5: A storage fault on a fetch (`sf_valid`=1, `sf_acc`=2) produces kind 3 one clock later. `flt_errcode` equals `sf_cause`, and `flt_status_we`=0 and `flt_addr_we`=0.
- R6: A storage fault on any data access produces kind 4 one clock later. `flt_status` holds the cause with `flt_status_we`=1, `flt_addr` holds `sf_ea` with `flt_addr_we`=1, and `flt_errcode`=0.
- R7: A data storage fault on a write ORs the store indicator, bit 25 of the status (mask 0x0200_0000), into the reported status. Reads leave that bit as the cause gives it.
- R8: When `hv_mode`=1 and the relevant relocation enable is 0 (`instr_reloc` for fetches, `data_reloc` otherwise), `real_mode`=1 and `real_addr` is `ea` with bits [63:60] cleared. `real_perm`=3'b111 (bit 0 read, bit 1 write, bit 2 execute), and no segment fault is raised. In every other case `real_mode`=0 and `real_perm`=0.
- R9: `flt_valid` is high for exactly one cycle per fault. The record fields hold their value until the next fault.
- R10: When a storage fault and a segment fault arrive in the same cycle, the storage fault is recorded.
- R11: After reset, `flt_valid`=0, `flt_kind`=0 (none) and all record fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| ea | input | 64 | Effective address of the request |
| acc_type | input | 2 | Access code of the request |
| hv_mode | input | 1 | Hypervisor mode |
| instr_reloc | input | 1 | Instruction relocation enable |
| data_reloc | input | 1 | Data relocation enable |
| part_reg | input | 12 | Partition identifier register |
| proc_reg | input | 20 | Process identifier register |
| qual_lpid | output | 12 | Qualified partition identifier |
| qual_pid | output | 20 | Qualified process identifier |
| qual_legal | output | 1 | Quadrant legal in current mode |
| real_mode | output | 1 | Access bypasses translation |
| real_addr | output | 64 | Real-mode address |
| real_perm | output | 3 | Granted permissions in real mode |
| sf_valid | input | 1 | Storage fault from the walker |
| sf_acc | input | 2 | Access code of the faulting access |
| sf_ea | input | 64 | Effective address of the faulting access |
| sf_cause | input | 32 | Fault cause bits |
| flt_valid | output | 1 | One-cycle fault record strobe |
| flt_kind | output | 3 | 0 none, 1 instr segment, 2 data segment, 3 instr storage, 4 data storage |
| flt_status | output | 32 | Status value to capture |
| flt_status_we | output | 1 | Status value is to be written |
| flt_addr | output | 64 | Fault address to capture |
| flt_addr_we | output | 1 | Fault address is to be written |
| flt_errcode | output | 32 | Interrupt error code |

## Verification
The qualifier and real-mode outputs have no register on their path, so they are due in the same cycle as the stimulus. The bench samples them two nanoseconds after driving, well before the next clock edge. The fault record passes through one register, so it is due at the first rising edge after the stimulus. The bench reads it at the following falling edge, then reads it again one cycle later to confirm that the strobe has dropped and the fields have held.

// File: rtl/xlat_qual_pkg.sv
package xlat_qual_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_ISEG  = 3'd1,
        FK_DSEG  = 3'd2,
        FK_ISTOR = 3'd3,
        FK_DSTOR = 3'd4
    } fkind_e;

    localparam int unsigned QUAD_W = 2;

endpackage

// File: rtl/xq_quadrant_map.sv
module xq_quadrant_map
    import xlat_qual_pkg::*;
#(
    parameter int unsigned LPID_W = 12,
    parameter int unsigned PID_W  = 20
) (
    input  logic              hv_mode,
    input  logic [QUAD_W-1:0] quad,
    input  logic [LPID_W-1:0] part_reg,
    input  logic [PID_W-1:0]  proc_reg,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid,
    output logic              legal
);
    logic use_part;
    logic use_proc;

    always_comb begin
        use_part = 1'b0;
        use_proc = 1'b0;
        legal    = 1'b1;
        if (hv_mode) begin
            unique case (quad)
                2'd0: begin use_part = 1'b0; use_proc = 1'b1; end
                2'd1: begin use_part = 1'b1; use_proc = 1'b1; end
                2'd2: begin use_part = 1'b1; use_proc = 1'b0; end
                default: begin use_part = 1'b0; use_proc = 1'b0; end
            endcase
        end else begin
            unique case (quad)
                2'd0: begin use_part = 1'b1; use_proc = 1'b1; end
                2'd3: begin use_part = 1'b1; use_proc = 1'b0; end
                default: legal = 1'b0;
            endcase
        end
        lpid = use_part ? part_reg : '0;
        pid  = use_proc ? proc_reg : '0;
    end

endmodule

// File: rtl/xq_real_bypass.sv
module xq_real_bypass
    import xlat_qual_pkg::*;
#(
    parameter int unsigned VA_W     = 64,
    parameter int unsigned CLR_BITS = 4,
    localparam int unsigned KEEP_W  = VA_W - CLR_BITS
) (
    input  logic              hv_mode,
    input  logic [1:0]        acc,
    input  logic              instr_reloc,
    input  logic              data_reloc,
    input  logic [KEEP_W-1:0] ea_low,
    output logic              real_mode,
    output logic [VA_W-1:0]   real_addr,
    output logic [2:0]        perm
);
    logic reloc_on;

    always_comb begin
        reloc_on  = (acc == ACC_FETCH) ? instr_reloc : data_reloc;
        real_mode = hv_mode && !reloc_on;
        real_addr = {{CLR_BITS{1'b0}}, ea_low};
        perm      = real_mode ? 3'b111 : 3'b000;
    end

endmodule

// File: rtl/xq_fault_build.sv
module xq_fault_build
    import xlat_qual_pkg::*;
#(
    parameter int unsigned VA_W      = 64,
    parameter int unsigned CAUSE_W   = 32,
    parameter int unsigned STORE_BIT = 25
) (
    input  logic               seg_req,
    input  logic [1:0]         seg_acc,
    input  logic [VA_W-1:0]    seg_ea,
    input  logic               sf_valid,
    input  logic [1:0]         sf_acc,
    input  logic [VA_W-1:0]    sf_ea,
    input  logic [CAUSE_W-1:0] sf_cause,
    output logic               fire,
    output fkind_e             kind,
    output logic [CAUSE_W-1:0] status,
    output logic               status_we,
    output logic [VA_W-1:0]    addr,
    output logic               addr_we,
    output logic [CAUSE_W-1:0] errcode
);
    localparam logic [CAUSE_W-1:0] STORE_MASK = {{(CAUSE_W-1){1'b0}}, 1'b1} << STORE_BIT;

    always_comb begin
        fire      = 1'b0;
        kind      = FK_NONE;
        status    = '0;
        status_we = 1'b0;
        addr      = '0;
        addr_we   = 1'b0;
        errcode   = '0;
        if (sf_valid) begin
            fire = 1'b1;
            if (sf_acc == ACC_FETCH) begin
                kind    = FK_ISTOR;
                errcode = sf_cause;
            end else begin
                kind      = FK_DSTOR;
                status    = sf_cause | ((sf_acc == ACC_WRITE) ? STORE_MASK : '0);
                status_we = 1'b1;
                addr      = sf_ea;
                addr_we   = 1'b1;
            end
        end else if (seg_req) begin
            fire = 1'b1;
            if (seg_acc == ACC_FETCH) begin
                kind = FK_ISEG;
            end else begin
                kind    = FK_DSEG;
                addr    = seg_ea;
                addr_we = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_ctx_qualifier.sv
module xlat_ctx_qualifier
    import xlat_qual_pkg::*;
#(
    parameter int unsigned VA_W      = 64,
    parameter int unsigned LPID_W    = 12,
    parameter int unsigned PID_W     = 20,
    parameter int unsigned CAUSE_W   = 32,
    parameter int unsigned STORE_BIT = 25,
    parameter int unsigned CLR_BITS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    ea,
    input  logic [1:0]         acc_type,
    input  logic               hv_mode,
    input  logic               instr_reloc,
    input  logic               data_reloc,
    input  logic [LPID_W-1:0]  part_reg,
    input  logic [PID_W-1:0]   proc_reg,
    output logic [LPID_W-1:0]  qual_lpid,
    output logic [PID_W-1:0]   qual_pid,
    output logic               qual_legal,
    output logic               real_mode,
    output logic [VA_W-1:0]    real_addr,
    output logic [2:0]         real_perm,
    input  logic               sf_valid,
    input  logic [1:0]         sf_acc,
    input  logic [VA_W-1:0]    sf_ea,
    input  logic [CAUSE_W-1:0] sf_cause,
    output logic               flt_valid,
    output logic [2:0]         flt_kind,
    output logic [CAUSE_W-1:0] flt_status,
    output logic               flt_status_we,
    output logic [VA_W-1:0]    flt_addr,
    output logic               flt_addr_we,
    output logic [CAUSE_W-1:0] flt_errcode
);
    localparam int unsigned KEEP_W = VA_W - CLR_BITS;

    typedef struct packed {
        logic               valid;
        fkind_e             kind;
        logic [CAUSE_W-1:0] status;
        logic               status_we;
        logic [VA_W-1:0]    addr;
        logic               addr_we;
        logic [CAUSE_W-1:0] errcode;
    } rec_t;

    rec_t rec_d, rec_q;

    logic               seg_req;
    logic               fb_fire;
    fkind_e             fb_kind;
    logic [CAUSE_W-1:0] fb_status;
    logic               fb_status_we;
    logic [VA_W-1:0]    fb_addr;
    logic               fb_addr_we;
    logic [CAUSE_W-1:0] fb_errcode;

    xq_quadrant_map #(.LPID_W(LPID_W), .PID_W(PID_W)) u_qmap (
        .hv_mode  (hv_mode),
        .quad     (ea[VA_W-1 -: QUAD_W]),
        .part_reg (part_reg),
        .proc_reg (proc_reg),
        .lpid     (qual_lpid),
        .pid      (qual_pid),
        .legal    (qual_legal)
    );

    xq_real_bypass #(.VA_W(VA_W), .CLR_BITS(CLR_BITS)) u_real (
        .hv_mode     (hv_mode),
        .acc         (acc_type),
        .instr_reloc (instr_reloc),
        .data_reloc  (data_reloc),
        .ea_low      (ea[KEEP_W-1:0]),
        .real_mode   (real_mode),
        .real_addr   (real_addr),
        .perm        (real_perm)
    );

    assign seg_req = req_valid && !real_mode && !qual_legal;

    xq_fault_build #(.VA_W(VA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_fb (
        .seg_req   (seg_req),
        .seg_acc   (acc_type),
        .seg_ea    (ea),
        .sf_valid  (sf_valid),
        .sf_acc    (sf_acc),
        .sf_ea     (sf_ea),
        .sf_cause  (sf_cause),
        .fire      (fb_fire),
        .kind      (fb_kind),
        .status    (fb_status),
        .status_we (fb_status_we),
        .addr      (fb_addr),
        .addr_we   (fb_addr_we),
        .errcode   (fb_errcode)
    );

    always_comb begin
        rec_d       = rec_q;
        rec_d.valid = 1'b0;
        if (fb_fire) begin
            rec_d.valid     = 1'b1;
            rec_d.kind      = fb_kind;
            rec_d.status    = fb_status;
            rec_d.status_we = fb_status_we;
            rec_d.addr      = fb_addr;
            rec_d.addr_we   = fb_addr_we;
            rec_d.errcode   = fb_errcode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '{valid: 1'b0, kind: FK_NONE, status: '0, status_we: 1'b0,
                       addr: '0, addr_we: 1'b0, errcode: '0};
        end else begin
            rec_q <= rec_d;
        end
    end

    assign flt_valid     = rec_q.valid;
    assign flt_kind      = rec_q.kind;
    assign flt_status    = rec_q.status;
    assign flt_status_we = rec_q.status_we;
    assign flt_addr      = rec_q.addr;
    assign flt_addr_we   = rec_q.addr_we;
    assign flt_errcode   = rec_q.errcode;

    // R2: hypervisor quadrant 3 forces both identifiers to zero
    a_r2_hv_q3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hv_mode && ea[VA_W-1 -: 2] == 2'd3 |-> qual_lpid == '0 && qual_pid == '0 && qual_legal);

    // R3: guest legality follows the quadrant
    a_r3_guest_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_mode |-> qual_legal == (ea[VA_W-1 -: 2] == 2'd0 || ea[VA_W-1 -: 2] == 2'd3));

    // R4: an illegal request yields a segment record on the next cycle
    a_r4_seg_record: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !real_mode && !qual_legal && !sf_valid |=>
            flt_valid && (flt_kind == FK_ISEG || flt_kind == FK_DSEG) && !flt_status_we);

    // R4: a data segment fault captures the address
    a_r4_dseg_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !real_mode && !qual_legal && !sf_valid && acc_type != ACC_FETCH |=>
            flt_addr == $past(ea) && flt_addr_we);

    // R5: fetch storage fault reports through the error code only
    a_r5_istor: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid && sf_acc == ACC_FETCH |=>
            flt_errcode == $past(sf_cause) && !flt_status_we && !flt_addr_we);

    // R6: data storage fault writes status and address and clears the error code
    a_r6_dstor: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid && sf_acc != ACC_FETCH |=>
            flt_kind == FK_DSTOR && flt_status_we && flt_errcode == '0 && flt_addr == $past(sf_ea));

    // R7: store indicator on write faults
    a_r7_store_bit: assert property (@(posedge clk) disable iff (!rst_n)
        sf_valid && sf_acc == ACC_WRITE |=> flt_status[STORE_BIT]);

    // R8: real mode clears the top bits and grants everything
    a_r8_real: assert property (@(posedge clk) disable iff (!rst_n)
        real_mode |-> real_addr[VA_W-1 -: CLR_BITS] == '0 && real_perm == 3'b111 && hv_mode);

    // R9: no stimulus, no strobe
    a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !sf_valid |=> !flt_valid);

endmodule

// File: tb/xlat_ctx_qualifier_tb.sv
module xlat_ctx_qualifier_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] ea = '0;
    logic [1:0]  acc_type = '0;
    logic        hv_mode = 1'b0;
    logic        instr_reloc = 1'b1;
    logic        data_reloc = 1'b1;
    logic [11:0] part_reg = 12'hA5C;
    logic [19:0] proc_reg = 20'h1B2C3;
    logic [11:0] qual_lpid;
    logic [19:0] qual_pid;
    logic        qual_legal, real_mode;
    logic [63:0] real_addr;
    logic [2:0]  real_perm;
    logic        sf_valid = 1'b0;
    logic [1:0]  sf_acc = '0;
    logic [63:0] sf_ea = '0;
    logic [31:0] sf_cause = '0;
    logic        flt_valid, flt_status_we, flt_addr_we;
    logic [2:0]  flt_kind;
    logic [31:0] flt_status, flt_errcode;
    logic [63:0] flt_addr;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    xlat_ctx_qualifier dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ea(ea), .acc_type(acc_type),
        .hv_mode(hv_mode), .instr_reloc(instr_reloc), .data_reloc(data_reloc),
        .part_reg(part_reg), .proc_reg(proc_reg), .qual_lpid(qual_lpid), .qual_pid(qual_pid),
        .qual_legal(qual_legal), .real_mode(real_mode), .real_addr(real_addr),
        .real_perm(real_perm), .sf_valid(sf_valid), .sf_acc(sf_acc), .sf_ea(sf_ea),
        .sf_cause(sf_cause), .flt_valid(flt_valid), .flt_kind(flt_kind),
        .flt_status(flt_status), .flt_status_we(flt_status_we), .flt_addr(flt_addr),
        .flt_addr_we(flt_addr_we), .flt_errcode(flt_errcode)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {hv, quad[1:0], acc[1:0], ir, dr, legal, real, lpid_from_reg, pid_from_reg}
    localparam int NV = 13;
    localparam logic [10:0] VEC [NV] = '{
        11'b1_00_00_11_1_0_0_1,  // R2 q0
        11'b1_01_01_11_1_0_1_1,  // R2 q1
        11'b1_10_10_11_1_0_1_0,  // R2 q2
        11'b1_11_00_11_1_0_0_0,  // R2 q3
        11'b0_00_10_11_1_0_1_1,  // R3 q0
        11'b0_11_01_11_1_0_1_0,  // R3 q3
        11'b0_01_10_11_0_0_0_0,  // R4 instr segment
        11'b0_10_00_11_0_0_0_0,  // R4 data segment
        11'b0_01_11_11_0_0_0_0,  // R1 code 3 as data
        11'b1_01_00_10_1_1_1_1,  // R8 data real
        11'b1_10_10_01_1_1_1_0,  // R8 fetch real
        11'b1_00_10_10_1_0_0_1,  // R8 fetch uses ir
        11'b0_01_00_10_0_0_0_0   // R8 guest never real
    };
    localparam logic [59:0] LOW60 = 60'h123456789ABCDEF;

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 valid", 64'(flt_valid), 64'd0);
        chk("R11 kind", 64'(flt_kind), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 addr", flt_addr, 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            logic exp_seg;
            v = VEC[i];
            hv_mode = v[10]; acc_type = v[7:6]; instr_reloc = v[5]; data_reloc = v[4];
            ea = {v[9:8], 2'b11, LOW60};
            req_valid = 1'b1;
            #2;
            chk($sformatf("R3 legal v%0d", i), 64'(qual_legal), 64'(v[3]));
            chk($sformatf("R8 real v%0d", i), 64'(real_mode), 64'(v[2]));
            chk($sformatf("R8 perm v%0d", i), 64'(real_perm), v[2] ? 64'd7 : 64'd0);
            if (v[2]) chk($sformatf("R8 addr v%0d", i), real_addr, {4'h0, ea[59:0]});
            if (v[3]) begin
                chk($sformatf("R2 lpid v%0d", i), 64'(qual_lpid), v[1] ? 64'(part_reg) : 64'd0);
                chk($sformatf("R2 pid v%0d", i), 64'(qual_pid), v[0] ? 64'(proc_reg) : 64'd0);
            end
            exp_seg = !v[3] && !v[2];
            @(negedge clk);
            chk($sformatf("R4 valid v%0d", i), 64'(flt_valid), 64'(exp_seg));
            if (exp_seg) begin
                if (v[7:6] == 2'd2) begin
                    chk($sformatf("R4 iseg kind v%0d", i), 64'(flt_kind), 64'd1);
                    chk($sformatf("R4 iseg addr_we v%0d", i), 64'(flt_addr_we), 64'd0);
                end else begin
                    chk($sformatf("R1 R4 dseg kind v%0d", i), 64'(flt_kind), 64'd2);
                    chk($sformatf("R4 dseg addr v%0d", i), flt_addr, ea);
                    chk($sformatf("R4 dseg addr_we v%0d", i), 64'(flt_addr_we), 64'd1);
                end
                chk($sformatf("R4 errcode v%0d", i), 64'(flt_errcode), 64'd0);
                chk($sformatf("R4 status_we v%0d", i), 64'(flt_status_we), 64'd0);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);

        // R5 fetch storage fault
        sf_valid = 1'b1; sf_acc = 2'd2; sf_cause = 32'h4000_0000; sf_ea = 64'hDEAD_0000_1000;
        @(negedge clk);
        sf_valid = 1'b0;
        chk("R5 valid", 64'(flt_valid), 64'd1);
        chk("R5 kind", 64'(flt_kind), 64'd3);
        chk("R5 errcode", 64'(flt_errcode), 64'h4000_0000);
        chk("R5 status_we", 64'(flt_status_we), 64'd0);
        chk("R5 addr_we", 64'(flt_addr_we), 64'd0);
        @(negedge clk);
        chk("R9 strobe drops", 64'(flt_valid), 64'd0);
        chk("R9 errcode holds", 64'(flt_errcode), 64'h4000_0000);

        // R6 data read storage fault
        sf_valid = 1'b1; sf_acc = 2'd0; sf_cause = 32'h0800_0000; sf_ea = 64'hBEEF_0000_2000;
        @(negedge clk);
        sf_valid = 1'b0;
        chk("R6 kind", 64'(flt_kind), 64'd4);
        chk("R6 R7 read status", 64'(flt_status), 64'h0800_0000);
        chk("R6 status_we", 64'(flt_status_we), 64'd1);
        chk("R6 addr", flt_addr, 64'hBEEF_0000_2000);
        chk("R6 addr_we", 64'(flt_addr_we), 64'd1);
        chk("R6 errcode cleared", 64'(flt_errcode), 64'd0);

        // R7 write adds store bit
        sf_valid = 1'b1; sf_acc = 2'd1; sf_cause = 32'h0800_0000;
        @(negedge clk);
        chk("R7 write status", 64'(flt_status), 64'h0A00_0000);
        sf_cause = 32'h0200_0001;
        @(negedge clk);
        chk("R7 bit already set", 64'(flt_status), 64'h0200_0001);
        sf_acc = 2'd3; sf_cause = 32'h0000_0010;
        @(negedge clk);
        sf_valid = 1'b0;
        chk("R1 code3 kind", 64'(flt_kind), 64'd4);
        chk("R1 code3 no store bit", 64'(flt_status), 64'h0000_0010);

        // R10 storage fault wins over segment fault
        hv_mode = 1'b0; instr_reloc = 1'b1; data_reloc = 1'b1; acc_type = 2'd2;
        ea = {2'b01, 2'b00, LOW60}; req_valid = 1'b1;
        sf_valid = 1'b1; sf_acc = 2'd1; sf_cause = 32'h0000_0100; sf_ea = 64'h77;
        @(negedge clk);
        req_valid = 1'b0; sf_valid = 1'b0;
        chk("R10 kind", 64'(flt_kind), 64'd4);
        chk("R10 addr", flt_addr, 64'h77);
        @(negedge clk);
        chk("R9 idle", 64'(flt_valid), 64'd0);

        // R11 reset clears record
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 kind after reset", 64'(flt_kind), 64'd0);
        chk("R11 status after reset", 64'(flt_status), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule